// File: doc/BRIEF.md
# Masked Burst Address Counter

This block generates the memory address for one port of a synchronous dual-port memory. It holds an address counter and a mask register, both as wide as the address bus. Bits whose mask bit is one take part in counting and clearing. Bits whose mask bit is zero stay fixed. This lets a burst run through an aligned window of the address space while the upper part of the address stays put.

On each clock, a small set of request inputs selects one operation: clear, load, a mask operation, counter readback, increment or hold. The counter and the mask can both be loaded from, and read back over, the same bidirectional address bus. The counter drives the memory address output directly. An active-low flag pulses when the counting bits wrap.

Top module: `burst_addr_gen`

## Requirements
- R1: Driving `mrst_n` low, asynchronously, sets the counter to zero, sets the mask to all ones, forces `cnt_flag_n` high and releases the address bus (`addr_oe` low).
- R2: `clr_req` clears only the counter bits whose mask bit is one. Bits whose mask bit is zero keep their value.
- R3: `load_req` copies the value on `addr_io` into the counter at the clock edge.
- R4: `inc_req` advances the masked-in bits as one binary count. A carry skips over masked-out positions, and masked-out bits never change.
- R5: With no request asserted, the counter holds its value over any number of clocks. `mem_addr` always equals the counter.
- R6: `rdbk_req` makes the block drive the counter value on `addr_io`, with `addr_oe` high, during the following clock cycle. The counter itself does not change.
- R7: `msk_req` with `msk_op` = 2'b00 sets the mask to all ones. With `msk_op` = 2'b01 it loads the mask from `addr_io`. Neither changes the counter.
- R8: `msk_req` with `msk_op` = 2'b10 drives the mask value on `addr_io`, with `addr_oe` high, during the following cycle.
- R9: `msk_req` with `msk_op` = 2'b11 is a reserved code. It changes neither register and leaves the bus undriven.
- R10: `cnt_flag_n` goes low for exactly one cycle after an increment that takes all masked-in bits from all ones to zero. This happens only when the mask is not zero.
- R11: When several requests are asserted together, the operation is chosen in this order: clear, then load, then the mask operation, then counter readback, then increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| mrst_n | input | 1 | Asynchronous master reset, active low |
| clr_req | input | 1 | Clear the masked-in counter bits |
| load_req | input | 1 | Load the counter from the address bus |
| msk_req | input | 1 | Perform the mask operation chosen by msk_op |
| msk_op | input | 2 | 00 reset, 01 load, 10 readback, 11 reserved |
| rdbk_req | input | 1 | Drive the counter onto the address bus next cycle |
| inc_req | input | 1 | Increment the masked-in bits |
| addr_io | inout | AW | Bidirectional address bus |
| mem_addr | output | AW | Effective memory address (the counter) |
| addr_oe | output | 1 | High while the block drives addr_io |
| cnt_flag_n | output | 1 | Wrap flag, active low, one cycle wide |

## Verification
On every cycle, the assertions check the following:
- clearing leaves the masked-out bits alone;
- a load takes the previous bus value;
- an idle or reserved cycle leaves both registers unchanged;
- the bus is enabled only after a readback request;
- the wrap flag lasts one cycle and appears only after an increment.

Some behaviour can only be shown by the bench's scenarios. This covers the arithmetic of an increment whose carry skips over scattered masked-out bits, the exact values read back over the bus, the priority among simultaneous requests, and the effect of an asynchronous reset in the middle of a cycle.

// File: rtl/bag_pkg.sv
package bag_pkg;
    typedef enum logic [3:0] {
        OP_HOLD,
        OP_INC,
        OP_CRD,
        OP_MSET,
        OP_MLD,
        OP_MRD,
        OP_RSVD,
        OP_LOAD,
        OP_CLR
    } bag_op_e;

    localparam logic [1:0] MOP_SET  = 2'b00;
    localparam logic [1:0] MOP_LOAD = 2'b01;
    localparam logic [1:0] MOP_READ = 2'b10;
endpackage

// File: rtl/bag_decode.sv
module bag_decode
    import bag_pkg::*;
(
    input  logic       clr_req,
    input  logic       load_req,
    input  logic       msk_req,
    input  logic [1:0] msk_op,
    input  logic       rdbk_req,
    input  logic       inc_req,
    output bag_op_e    op
);
    always_comb begin
        if (clr_req) begin
            op = OP_CLR;
        end else if (load_req) begin
            op = OP_LOAD;
        end else if (msk_req) begin
            unique case (msk_op)
                MOP_SET:  op = OP_MSET;
                MOP_LOAD: op = OP_MLD;
                MOP_READ: op = OP_MRD;
                default:  op = OP_RSVD;
            endcase
        end else if (rdbk_req) begin
            op = OP_CRD;
        end else if (inc_req) begin
            op = OP_INC;
        end else begin
            op = OP_HOLD;
        end
    end
endmodule

// File: rtl/bag_step.sv
module bag_step #(
    parameter int AW = 18
) (
    input  logic [AW-1:0] cnt,
    input  logic [AW-1:0] msk,
    output logic [AW-1:0] inc_val,
    output logic [AW-1:0] clr_val,
    output logic          wrap
);
    logic [AW-1:0] filled;
    logic [AW-1:0] summed;

    // masked-out positions are forced to one so a carry ripples past them
    always_comb begin
        filled  = cnt | ~msk;
        summed  = filled + {{(AW-1){1'b0}}, 1'b1};
        inc_val = (cnt & ~msk) | (summed & msk);
        clr_val = cnt & ~msk;
        wrap    = (|msk) && (&filled);
    end
endmodule

// File: rtl/bag_bus.sv
module bag_bus #(
    parameter int AW = 18
) (
    input  logic          oe,
    input  logic [AW-1:0] val,
    output logic [AW-1:0] rd,
    inout  wire  [AW-1:0] io
);
    assign io = oe ? val : {AW{1'bz}};
    assign rd = io;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          clr_req,
    input  logic          load_req,
    input  logic          msk_req,
    input  logic [1:0]    msk_op,
    input  logic          rdbk_req,
    input  logic          inc_req,
    inout  wire  [AW-1:0] addr_io,
    output logic [AW-1:0] mem_addr,
    output logic          addr_oe,
    output logic          cnt_flag_n
);
    typedef struct packed {
        logic [AW-1:0] cnt;
        logic [AW-1:0] msk;
        logic          oe;
        logic [AW-1:0] rbv;
        logic          flag_n;
    } st_t;

    st_t           st_d, st_q;
    bag_op_e       op;
    logic [AW-1:0] bus_rd;
    logic [AW-1:0] inc_val;
    logic [AW-1:0] clr_val;
    logic          wrap;

    bag_decode u_dec (
        .clr_req  (clr_req),
        .load_req (load_req),
        .msk_req  (msk_req),
        .msk_op   (msk_op),
        .rdbk_req (rdbk_req),
        .inc_req  (inc_req),
        .op       (op)
    );

    bag_step #(.AW(AW)) u_step (
        .cnt     (st_q.cnt),
        .msk     (st_q.msk),
        .inc_val (inc_val),
        .clr_val (clr_val),
        .wrap    (wrap)
    );

    bag_bus #(.AW(AW)) u_bus (
        .oe  (st_q.oe),
        .val (st_q.rbv),
        .rd  (bus_rd),
        .io  (addr_io)
    );

    always_comb begin
        st_d        = st_q;
        st_d.oe     = 1'b0;
        st_d.flag_n = 1'b1;
        unique case (op)
            OP_CLR:  st_d.cnt = clr_val;
            OP_LOAD: st_d.cnt = bus_rd;
            OP_MSET: st_d.msk = '1;
            OP_MLD:  st_d.msk = bus_rd;
            OP_MRD: begin
                st_d.oe  = 1'b1;
                st_d.rbv = st_q.msk;
            end
            OP_CRD: begin
                st_d.oe  = 1'b1;
                st_d.rbv = st_q.cnt;
            end
            OP_INC: begin
                st_d.cnt    = inc_val;
                st_d.flag_n = ~wrap;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) begin
            st_q.cnt    <= '0;
            st_q.msk    <= '1;
            st_q.oe     <= 1'b0;
            st_q.rbv    <= '0;
            st_q.flag_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr   = st_q.cnt;
    assign addr_oe    = st_q.oe;
    assign cnt_flag_n = st_q.flag_n;
endmodule

// File: rtl/bag_chk.sv
module bag_chk #(
    parameter int AW = 18
) (
    input logic          clk,
    input logic          mrst_n,
    input logic          clr_req,
    input logic          load_req,
    input logic          msk_req,
    input logic [1:0]    msk_op,
    input logic          rdbk_req,
    input logic          inc_req,
    input logic [AW-1:0] addr_io,
    input logic [AW-1:0] mem_addr,
    input logic          addr_oe,
    input logic          cnt_flag_n,
    input logic [AW-1:0] msk
);
    logic past_ok;
    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) past_ok <= 1'b0;
        else         past_ok <= 1'b1;
    end

    logic idle, rsvd, rb_any, inc_only;
    assign idle     = !clr_req && !load_req && !msk_req && !rdbk_req && !inc_req;
    assign rsvd     = !clr_req && !load_req && msk_req && (msk_op == 2'b11);
    assign rb_any   = !clr_req && !load_req &&
                      ((msk_req && msk_op == 2'b10) || (!msk_req && rdbk_req));
    assign inc_only = inc_req && !clr_req && !load_req && !msk_req && !rdbk_req;

    a_r2_clr_keeps_masked: assert property (@(posedge clk) disable iff (!mrst_n)
        past_ok && $past(clr_req) |->
            ((mem_addr & $past(msk)) == '0) &&
            ((mem_addr & ~$past(msk)) == ($past(mem_addr) & ~$past(msk))));

    a_r3_load_takes_bus: assert property (@(posedge clk) disable iff (!mrst_n)
        past_ok && $past(load_req && !clr_req) |-> mem_addr == $past(addr_io));

    a_r5_idle_holds: assert property (@(posedge clk) disable iff (!mrst_n)
        past_ok && $past(idle) |-> mem_addr == $past(mem_addr));

    a_r9_reserved_inert: assert property (@(posedge clk) disable iff (!mrst_n)
        past_ok && $past(rsvd) |->
            (mem_addr == $past(mem_addr)) && (msk == $past(msk)) && !addr_oe);

    a_r6_oe_cause: assert property (@(posedge clk) disable iff (!mrst_n)
        past_ok && addr_oe |-> $past(rb_any));

    a_r10_flag_cause: assert property (@(posedge clk) disable iff (!mrst_n)
        past_ok && !cnt_flag_n |-> $past(inc_only));

    a_r10_flag_pulse: assert property (@(posedge clk) disable iff (!mrst_n)
        !cnt_flag_n |=> cnt_flag_n);
endmodule

bind burst_addr_gen bag_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .mrst_n     (mrst_n),
    .clr_req    (clr_req),
    .load_req   (load_req),
    .msk_req    (msk_req),
    .msk_op     (msk_op),
    .rdbk_req   (rdbk_req),
    .inc_req    (inc_req),
    .addr_io    (addr_io),
    .mem_addr   (mem_addr),
    .addr_oe    (addr_oe),
    .cnt_flag_n (cnt_flag_n),
    .msk        (st_q.msk)
);

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
    localparam int AW = 18;

    localparam logic [3:0] H = 4'd0, I = 4'd1, C = 4'd2, L = 4'd3, ML = 4'd4,
                           MR = 4'd5, CR = 4'd6, MB = 4'd7, RS = 4'd8,
                           PRI = 4'd9, LI = 4'd10, MI = 4'd11;

    typedef struct packed {
        logic [3:0]    op;
        logic [AW-1:0] din;
        logic [AW-1:0] ea;
        logic          ef;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VT [NV] = '{
        '{L,   18'h3FFFE, 18'h3FFFE, 1'b1},
        '{I,   18'h0,     18'h3FFFF, 1'b1},
        '{I,   18'h0,     18'h00000, 1'b0},
        '{I,   18'h0,     18'h00001, 1'b1},
        '{H,   18'h0,     18'h00001, 1'b1},
        '{ML,  18'h0000F, 18'h00001, 1'b1},
        '{L,   18'h1230E, 18'h1230E, 1'b1},
        '{I,   18'h0,     18'h1230F, 1'b1},
        '{I,   18'h0,     18'h12300, 1'b0},
        '{I,   18'h0,     18'h12301, 1'b1},
        '{ML,  18'h0000A, 18'h12301, 1'b1},
        '{I,   18'h0,     18'h12303, 1'b1},
        '{I,   18'h0,     18'h12309, 1'b1},
        '{I,   18'h0,     18'h1230B, 1'b1},
        '{I,   18'h0,     18'h12301, 1'b0},
        '{I,   18'h0,     18'h12303, 1'b1},
        '{C,   18'h0,     18'h12301, 1'b1},
        '{MR,  18'h0,     18'h12301, 1'b1},
        '{C,   18'h0,     18'h00000, 1'b1},
        '{RS,  18'h0,     18'h00000, 1'b1},
        '{L,   18'h00777, 18'h00777, 1'b1},
        '{PRI, 18'h00055, 18'h00000, 1'b1},
        '{LI,  18'h00100, 18'h00100, 1'b1},
        '{MI,  18'h3FFF0, 18'h00100, 1'b1},
        '{I,   18'h0,     18'h00110, 1'b1},
        '{MR,  18'h0,     18'h00110, 1'b1}
    };

    logic          clk = 1'b0;
    logic          mrst_n = 1'b0;
    logic          clr_req = 0, load_req = 0, msk_req = 0, rdbk_req = 0, inc_req = 0;
    logic [1:0]    msk_op = 2'b00;
    logic [AW-1:0] tb_val = '0;
    logic          tb_drv = 1'b0;
    wire  [AW-1:0] addr_io;
    logic [AW-1:0] mem_addr;
    logic          addr_oe, cnt_flag_n;
    int            errors = 0, checks = 0;
    logic          done = 1'b0;

    assign addr_io = tb_drv ? tb_val : {AW{1'bz}};

    always #2.5 clk = ~clk;

    burst_addr_gen #(.AW(AW)) u0 (
        .clk(clk), .mrst_n(mrst_n), .clr_req(clr_req), .load_req(load_req),
        .msk_req(msk_req), .msk_op(msk_op), .rdbk_req(rdbk_req), .inc_req(inc_req),
        .addr_io(addr_io), .mem_addr(mem_addr), .addr_oe(addr_oe),
        .cnt_flag_n(cnt_flag_n)
    );

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            I:       return "R4";
            C:       return "R2";
            L:       return "R3";
            ML, MR:  return "R7";
            RS:      return "R9";
            PRI, LI, MI: return "R11";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string rq, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic set_ops(input logic [3:0] op, input logic [AW-1:0] din);
        clr_req = 0; load_req = 0; msk_req = 0; rdbk_req = 0; inc_req = 0;
        msk_op = 2'b00; tb_drv = 1'b0; tb_val = din;
        case (op)
            I:   inc_req = 1;
            C:   clr_req = 1;
            L:   begin load_req = 1; tb_drv = 1; end
            ML:  begin msk_req = 1; msk_op = 2'b01; tb_drv = 1; end
            MR:  begin msk_req = 1; msk_op = 2'b00; end
            CR:  rdbk_req = 1;
            MB:  begin msk_req = 1; msk_op = 2'b10; end
            RS:  begin msk_req = 1; msk_op = 2'b11; end
            PRI: begin clr_req = 1; load_req = 1; inc_req = 1; tb_drv = 1; end
            LI:  begin load_req = 1; inc_req = 1; tb_drv = 1; end
            MI:  begin msk_req = 1; msk_op = 2'b01; inc_req = 1; tb_drv = 1; end
            default: ;
        endcase
    endtask

    task automatic step(input logic [3:0] op, input logic [AW-1:0] din);
        set_ops(op, din);
        @(posedge clk);
        @(negedge clk);
        set_ops(H, '0);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset addr", mem_addr, '0);
        chk("R1 reset flag", {17'b0, cnt_flag_n}, 18'h1);
        chk("R1 reset oe", {17'b0, addr_oe}, 18'h0);
        mrst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            step(VT[k].op, VT[k].din);
            chk(tag_of(VT[k].op), mem_addr, VT[k].ea);
            chk("R10 flag", {17'b0, cnt_flag_n}, {17'b0, VT[k].ef});
        end

        // R6: counter readback
        step(CR, '0);
        chk("R6 oe", {17'b0, addr_oe}, 18'h1);
        chk("R6 bus", addr_io, 18'h00110);
        chk("R6 counter kept", mem_addr, 18'h00110);
        step(H, '0);
        chk("R6 oe drops", {17'b0, addr_oe}, 18'h0);

        // R8: mask readback
        step(ML, 18'h3C3C3);
        step(MB, '0);
        chk("R8 oe", {17'b0, addr_oe}, 18'h1);
        chk("R8 bus", addr_io, 18'h3C3C3);
        step(H, '0);
        step(MR, '0);
        step(MB, '0);
        chk("R7 mask reset", addr_io, 18'h3FFFF);
        step(H, '0);

        // R9: reserved code leaves bus and mask alone
        step(RS, '0);
        chk("R9 no drive", {17'b0, addr_oe}, 18'h0);
        chk("R9 counter", mem_addr, 18'h00110);
        step(MB, '0);
        chk("R9 mask kept", addr_io, 18'h3FFFF);
        step(H, '0);

        // R10 then R1: wrap with a window mask, then async reset mid-cycle
        step(ML, 18'h00FF0);
        step(L, 18'h3FFFF);
        step(I, '0);
        chk("R10 window wrap", mem_addr, 18'h3F00F);
        chk("R10 flag low", {17'b0, cnt_flag_n}, 18'h0);
        #1 mrst_n = 1'b0;
        #1;
        chk("R1 async flag", {17'b0, cnt_flag_n}, 18'h1);
        chk("R1 async addr", mem_addr, '0);
        @(negedge clk);
        mrst_n = 1'b1;
        @(negedge clk);
        step(MB, '0);
        chk("R1 mask ones", addr_io, 18'h3FFFF);
        step(H, '0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule